// File: doc/BRIEF.md
# Viterbi Survivor-Path Trace-Back Walker

This block rebuilds the surviving path of a Viterbi decoder by walking the trellis backward, one stage per accepted decision vector. Software or a sequencer gives it a starting trellis state, a walk length and a run-time constraint length K. It then consumes decision vectors newest-first. A decision vector holds one survivor bit per trellis state. At each step the walker does three things. It reads the survivor bit indexed by its current state. It emits the state's least significant bit as a decoded bit. It forms the predecessor state by shifting right and dropping the survivor bit into the top position of the active K-1 bits.

K ranges from 3 to 9, so the state register is 8 bits wide. Its active length is set by a chain of seven 2-to-1 multiplexers that pick where the survivor bit lands. Bits at and above position K-1 are always zero, so they never take part in selecting a survivor bit. Decoded bits come out in reverse time order, and a downstream stage reverses them.

The controller has three states. IDLE waits for `start_i`. IDLE→WALK is taken on start with a non-zero length, and IDLE→FINISH on start with a zero length. WALK performs one step on each cycle where `dec_valid_i` is high. WALK→FINISH is taken on the step that consumes the last count. FINISH raises `done_o` for one cycle, and FINISH→IDLE is unconditional.

Top module: `trellis_backtrack`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `bit_valid_o` and `done_o` are low and `state_o` is zero.
- R2: At start, K is taken from `k_cfg_i`. Values below 3 become 3 and values above 9 become 9. The loaded state equals `init_state_i` with every bit at position K-1 or higher cleared, and those bits stay zero throughout the walk.
- R3: The survivor bit of a step is bit number S of `dec_vec_i`, where S is the current state read as an unsigned integer.
- R4: After a step the state becomes (S >> 1) with the survivor bit placed at position K-2.
- R5: A step taken at a clock edge raises `bit_valid_o` for the following cycle, and `bit_o` then equals bit 0 of the state before that step.
- R6: In WALK, a cycle with `dec_valid_i` low performs no step: `state_o` holds and `bit_valid_o` stays low.
- R7: Exactly N steps are made for a length N. `done_o` is high for exactly the one cycle after the final step's edge, and then the walker returns to idle. With N = 0, `done_o` pulses in the cycle after start and no bit is emitted.
- R8: `start_i` is ignored while `busy_o` is high. It changes neither the state, the remaining count nor the constraint length.
- R9: `k_cfg_i` is sampled only when a start is accepted. Changing it during a walk has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (honoured only when idle) |
| k_cfg_i | input | 4 | Constraint length request, clamped to 3..9 |
| init_state_i | input | 8 | Starting trellis state |
| steps_i | input | 16 | Number of trace-back steps |
| dec_valid_i | input | 1 | Decision vector present this cycle |
| dec_vec_i | input | 256 | Decision vector, bit i belongs to state i |
| busy_o | output | 1 | High in WALK and FINISH |
| bit_valid_o | output | 1 | Decoded bit strobe |
| bit_o | output | 1 | Decoded bit, reverse time order |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| state_o | output | 8 | Current trellis state |

## Verification
The bench sweeps every legal K with several starting states, including all-ones. All-ones exposes a walker that fails to mask bits above K-2; such a walker would index decision bits of non-existent states. For each K, the bench checks that the survivor bit lands at position K-2, which catches a mux chain that inserts one position off for some K. It requests out-of-range K values to catch a missing clamp. A zero-length walk would hang or emit a stray bit in a design that decrements before testing. Gaps in `dec_valid_i` catch a walker that steps on stale vectors. A start pulse and a K change injected mid-walk would restart the walk or reshape the register in a design that samples them there.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WALK   = 2'd1,
        ST_FINISH = 2'd2
    } walk_st_e;

    localparam int unsigned K_FLOOR = 3;

endpackage

// File: rtl/tbk_bit_pick.sv
module tbk_bit_pick #(
    parameter int unsigned SW = 8,
    localparam int unsigned DW = 1 << SW
) (
    input  logic [DW-1:0] vec_i,
    input  logic [SW-1:0] idx_i,
    output logic          bit_o
);

    // Binary reduction tree: each level halves the candidates using one index bit.
    generate
        for (genvar lv = 0; lv <= SW; lv++) begin : g_lvl
            logic [(DW >> lv)-1:0] node;
            if (lv == 0) begin : g_leaf
                assign node = vec_i;
            end else begin : g_mux
                for (genvar n = 0; n < (DW >> lv); n++) begin : g_n
                    assign node[n] = idx_i[lv-1] ? g_lvl[lv-1].node[2*n+1]
                                                 : g_lvl[lv-1].node[2*n];
                end
            end
        end
    endgenerate

    assign bit_o = g_lvl[SW].node[0];

endmodule

// File: rtl/tbk_shift_mux.sv
module tbk_shift_mux #(
    parameter int unsigned SW = 8,
    parameter int unsigned KW = 4
) (
    input  logic [SW-1:0] cur_i,
    input  logic          surv_i,
    input  logic [KW-1:0] k_i,
    output logic [SW-1:0] nxt_o
);

    // Position 0 always receives the shifted bit because K is at least 3.
    // Positions 1..SW-1 each carry one 2-to-1 mux choosing between the
    // survivor bit (when the position equals K-2) and the shifted bit.
    generate
        for (genvar p = 0; p < SW; p++) begin : g_pos
            logic shifted;
            if (p < SW - 1) begin : g_src
                assign shifted = cur_i[p+1];
            end else begin : g_top
                assign shifted = 1'b0;
            end

            if (p == 0) begin : g_fixed
                assign nxt_o[p] = shifted;
            end else begin : g_sel
                logic at_ins;
                logic below;
                assign at_ins   = (k_i == KW'(p + 2));
                assign below    = (KW'(p + 2) < k_i);
                assign nxt_o[p] = at_ins ? surv_i : (below ? shifted : 1'b0);
            end
        end
    endgenerate

endmodule

// File: rtl/tbk_step_ctr.sv
module tbk_step_ctr #(
    parameter int unsigned LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [LW-1:0] load_val_i,
    input  logic          dec_i,
    output logic          last_o
);

    logic [LW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == LW'(1));

    AST_CTR_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (cnt_q != '0)); // R7

endmodule

// File: rtl/trellis_backtrack.sv
module trellis_backtrack
    import tbk_pkg::*;
#(
    parameter int unsigned MAX_K = 9,
    parameter int unsigned LEN_W = 16,
    parameter int unsigned KW    = 4,
    localparam int unsigned SW   = MAX_K - 1,
    localparam int unsigned DW   = 1 << SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [KW-1:0] k_cfg_i,
    input  logic [SW-1:0] init_state_i,
    input  logic [LEN_W-1:0] steps_i,
    input  logic          dec_valid_i,
    input  logic [DW-1:0] dec_vec_i,
    output logic          busy_o,
    output logic          bit_valid_o,
    output logic          bit_o,
    output logic          done_o,
    output logic [SW-1:0] state_o
);

    walk_st_e fsm_q, fsm_d;

    logic [KW-1:0] k_q;
    logic [KW-1:0] k_clamped;
    logic [SW-1:0] st_q;
    logic [SW-1:0] st_step;
    logic [SW-1:0] load_mask;
    logic [SW-1:0] live_mask;
    logic          bit_q, bv_q;
    logic          surv;
    logic          step_fire;
    logic          accept;
    logic          cnt_last;

    // ---------------- configuration ----------------
    always_comb begin
        if (k_cfg_i < KW'(K_FLOOR)) begin
            k_clamped = KW'(K_FLOOR);
        end else if (k_cfg_i > KW'(MAX_K)) begin
            k_clamped = KW'(MAX_K);
        end else begin
            k_clamped = k_cfg_i;
        end
    end

    generate
        for (genvar i = 0; i < SW; i++) begin : g_mask
            assign load_mask[i] = (KW'(i + 1) < k_clamped);
            assign live_mask[i] = (KW'(i + 1) < k_q);
        end
    endgenerate

    assign accept    = (fsm_q == ST_IDLE) && start_i;
    assign step_fire = (fsm_q == ST_WALK) && dec_valid_i;

    // ---------------- datapath pieces ----------------
    tbk_bit_pick #(.SW(SW)) u_pick (
        .vec_i (dec_vec_i),
        .idx_i (st_q),
        .bit_o (surv)
    );

    tbk_shift_mux #(.SW(SW), .KW(KW)) u_shift (
        .cur_i  (st_q),
        .surv_i (surv),
        .k_i    (k_q),
        .nxt_o  (st_step)
    );

    tbk_step_ctr #(.LW(LEN_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (accept),
        .load_val_i (steps_i),
        .dec_i      (step_fire),
        .last_o     (cnt_last)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= ST_IDLE;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE: begin
                if (start_i) begin
                    fsm_d = (steps_i == '0) ? ST_FINISH : ST_WALK;
                end
            end
            ST_WALK: begin
                if (dec_valid_i && cnt_last) begin
                    fsm_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                fsm_d = ST_IDLE;
            end
            default: begin
                fsm_d = ST_IDLE;
            end
        endcase
    end

    // ---------------- data registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q   <= KW'(K_FLOOR);
            st_q  <= '0;
            bit_q <= 1'b0;
            bv_q  <= 1'b0;
        end else begin
            bv_q <= step_fire;
            if (accept) begin
                k_q  <= k_clamped;
                st_q <= init_state_i & load_mask;
            end else if (step_fire) begin
                st_q  <= st_step;
                bit_q <= st_q[0];
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy_o      = (fsm_q != ST_IDLE);
        done_o      = (fsm_q == ST_FINISH);
        bit_valid_o = bv_q;
        bit_o       = bit_q;
        state_o     = st_q;
    end

    // ---------------- assertions ----------------
    AST_K_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (k_q >= KW'(K_FLOOR)) && (k_q <= KW'(MAX_K))); // R2

    AST_STATE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q & ~live_mask) == '0); // R2

    AST_SURVIVOR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        step_fire |=> (((st_q >> (k_q - KW'(2))) & SW'(1)) == SW'($past(surv)))); // R4

    AST_BIT_FROM_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        step_fire |=> (bit_valid_o && (bit_o == $past(st_q[0])))); // R5

    AST_NO_STEP_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((fsm_q == ST_WALK) && !dec_valid_i) |=> ($stable(st_q) && !bit_valid_o)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !step_fire) |=> $stable(st_q)); // R8

    AST_K_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q != ST_IDLE) |=> $stable(k_q)); // R9

endmodule

// File: tb/sim_trellis_backtrack.sv
module sim_trellis_backtrack;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [3:0]   k_cfg_i = 4'd3;
    logic [7:0]   init_state_i = '0;
    logic [15:0]  steps_i = '0;
    logic         dec_valid_i = 1'b0;
    logic [255:0] dec_vec_i = '0;
    logic         busy_o, bit_valid_o, bit_o, done_o;
    logic [7:0]   state_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    trellis_backtrack u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .k_cfg_i(k_cfg_i),
        .init_state_i(init_state_i), .steps_i(steps_i),
        .dec_valid_i(dec_valid_i), .dec_vec_i(dec_vec_i),
        .busy_o(busy_o), .bit_valid_o(bit_valid_o), .bit_o(bit_o),
        .done_o(done_o), .state_o(state_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit dec_bit(input int s, input int b, input int k);
        return (((b * 13) + (s * 7) + (k * 3) + (b >> 3)) % 5) < 2;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic run_walk(input int kcfg, input int init, input int n,
                            input int gap, input bit disturb);
        int ke = (kcfg < 3) ? 3 : ((kcfg > 9) ? 9 : kcfg);
        logic [7:0] st = 8'(init) & 8'((1 << (ke - 1)) - 1);
        @(negedge clk);
        k_cfg_i = 4'(kcfg); init_state_i = 8'(init); steps_i = 16'(n); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (n == 0) begin
            chk(done_o && !bit_valid_o, "R7 zero-length done", {done_o, bit_valid_o}, 2);
            @(negedge clk);
            chk(!done_o && !busy_o, "R7 zero-length idle", {done_o, busy_o}, 0);
            return;
        end
        chk(busy_o && state_o == st, "R2 masked load", state_o, st);
        for (int s = 0; s < n; s++) begin
            logic [255:0] v;
            bit eb, sv;
            if (gap > 0 && (s % gap) == gap - 1) begin
                dec_valid_i = 1'b0;
                dec_vec_i = ~dec_vec_i;
                @(negedge clk);
                chk(!bit_valid_o && state_o == st, "R6 hold without valid", state_o, st);
            end
            if (disturb && s == 3) begin
                start_i = 1'b1; init_state_i = ~8'(init); steps_i = 16'd2;
                k_cfg_i = (ke == 9) ? 4'd3 : 4'd9;
            end
            for (int b = 0; b < 256; b++) v[b] = dec_bit(s, b, ke);
            dec_vec_i = v; dec_valid_i = 1'b1;
            eb = st[0];
            sv = v[st];
            st = (st >> 1) | (8'(sv) << (ke - 2));
            @(negedge clk);
            start_i = 1'b0; dec_valid_i = 1'b0;
            chk(bit_valid_o && bit_o == eb, "R5 decoded bit", {bit_valid_o, bit_o}, {1'b1, eb});
            chk(state_o == st, disturb ? "R8 R9 R3 R4 predecessor" : "R3 R4 predecessor",
                state_o, st);
            if (s == n - 1) chk(done_o, "R7 done on final", done_o, 1);
            else            chk(!done_o, "R7 no early done", done_o, 0);
        end
        @(negedge clk);
        chk(!done_o && !busy_o && !bit_valid_o, "R7 single done and idle",
            {done_o, busy_o, bit_valid_o}, 0);
    endtask

    initial begin
        #1;
        chk(!busy_o && !bit_valid_o && !done_o && state_o == 0, "R1 reset",
            {busy_o, bit_valid_o, done_o}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && state_o == 0, "R1 after release", state_o, 0);

        for (int k = 3; k <= 9; k++) begin
            run_walk(k, 8'hFF, 12, 5, 1'b0);
            run_walk(k, 8'h00, 10, 0, 1'b0);
            run_walk(k, 8'h5A, 9, 3, 1'b0);
            run_walk(k, 8'hA5, 11, 4, 1'b0);
        end
        for (int i = 0; i < 4; i++) run_walk(3, i, 6, 0, 1'b0);

        run_walk(0, 8'hFF, 5, 0, 1'b0);   // R2 clamp low
        run_walk(2, 8'hFF, 5, 2, 1'b0);   // R2 clamp low
        run_walk(10, 8'hFF, 5, 0, 1'b0);  // R2 clamp high
        run_walk(15, 8'hC3, 5, 0, 1'b0);  // R2 clamp high

        run_walk(5, 8'h1D, 0, 0, 1'b0);   // R7 zero length
        run_walk(1, 8'h01, 1, 0, 1'b0);   // R7 single step
        run_walk(4, 8'h07, 8, 0, 1'b1);   // R8 R9 disturbance
        run_walk(9, 8'hE6, 9, 2, 1'b1);   // R8 R9 disturbance

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule